// File: doc/BRIEF.md
# Key Matrix Scanner with Serial Read Request

This block scans a 5 by 5 key matrix. It drives five strobe lines one at a time and samples five return inputs. The result of each full pass is kept in a 25-bit key register. A host controller talks to the block over a simple serial port made of a chip-enable, a serial clock, a data input and an open-drain data output. The block signals that key data is ready by pulling the data output low. It does this only after a key has been held down for a long, fixed number of clocks. The host then sends the key-read address and shifts the key bits out.

A control write over the same port selects a low-power sleep mode. In sleep, no scan runs. The strobe lines rest at fixed levels chosen by a two-bit select, and the scan-clock enable output is low. A press on any key that sits on a high strobe line raises the enable and starts scanning. Scanning goes on until one full pass finds no key down, and then the block returns to rest. Reading the keys clears the request and starts a fresh pass, but it does not leave sleep. Only a control write does that.

The serial inputs and the return lines are taken to be synchronous to `clk`. Serial clock edges are found by sampling the serial clock in the system clock domain.

Top module: `keyscan_ctrl`

## Requirements
- R1: While `scan_en` is high, exactly one strobe is high. Strobes are visited in the order 0,1,2,3,4,0,… and each one stays high for `SLOT_CLKS` clocks.
- R2: A key on strobe s and return r is reported in key-data bit s*5+r. Every key pressed at the same time appears as its own set bit, with no priority applied.
- R3: In sleep at rest, the strobe levels follow the 2-bit level select. 00 gives all strobes low, 01 gives only strobe 4 high, 10 gives strobes 3 and 4 high, and 11 gives all strobes high.
- R4: In sleep at rest, a return input going high raises `scan_en` and starts scanning. A key whose strobe is held low does not wake the block.
- R5: In sleep, `scan_en` falls only at the end of a full pass in which no key was seen. Outside sleep it stays high.
- R6: `sdo_drive_low` is raised as a request only after the key data has been non-zero for `HOLD_CLKS` (default 38400) consecutive clocks, and never earlier.
- R7: While `ser_ce` is high in any transfer other than a key read, the data output is released, which masks a pending request.
- R8: The host shifts an address byte in LSB first on rising serial clock edges while `ser_ce` is low, then raises `ser_ce`. For address 8Fh, the 25 key bits come out LSB first. Bit 0 is valid once `ser_ce` is high, and each later bit is valid after a falling serial clock edge. A data 0 is a low output.
- R9: A key read of at least 25 serial clocks clears the request and restarts the scan. Sleep is kept. A new request is not raised while the same hold continues.
- R10: A write to address 8Ch with 8 data bits, LSB first, sets sleep from data bit 0 and the level select from data bits 2:1. A transfer to any other address changes nothing.
- R11: Releasing every key resets the hold count, so a new request needs a fresh full hold.
- R12: After reset, sleep is off, `scan_en` is high and no request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_ce | input | 1 | Serial chip-enable. Low for the address byte, high for the data phase |
| ser_clk | input | 1 | Serial clock from the host |
| ser_din | input | 1 | Serial data from the host |
| sdo_drive_low | output | 1 | High pulls the open-drain data-out line low |
| strobe_o | output | 5 | Matrix strobe lines |
| return_i | input | 5 | Matrix return lines |
| scan_en | output | 1 | Scan clock enable |

## Verification
A new key pass lands in the key register at the end of the strobe-4 slot. A press therefore shows up within two passes (40 clocks by default), and the bench waits at least that long before it reads or checks for a release. The request rises `HOLD_CLKS` clocks after the key register becomes non-zero. The bench checks it is absent one clock short of `HOLD_CLKS` after the press and present `HOLD_CLKS`+45 clocks after the press. Serial edges take effect one clock after they are sampled, so the bench holds each serial level for two clocks. It reads data-out just before each rising edge and samples everything on the falling system clock edge.

// File: rtl/keyscan_pkg.sv
package keyscan_pkg;

    localparam int N_STROBE = 5;
    localparam int N_RETURN = 5;
    localparam int KEY_BITS = N_STROBE * N_RETURN;
    localparam int CMD_BITS = 8;

    typedef enum logic [1:0] {
        XFER_IDLE,
        XFER_READ,
        XFER_CTRL
    } xfer_e;

    typedef struct packed {
        logic       sleep;
        logic [1:0] lvl_sel;
    } ctrl_t;

    // Rest levels of the strobes while asleep and not scanning.
    function automatic logic [N_STROBE-1:0] sleep_levels(input logic [1:0] sel);
        logic [N_STROBE-1:0] lv;
        case (sel)
            2'b00:   lv = '0;
            2'b01:   lv = N_STROBE'(1) << (N_STROBE - 1);
            2'b10:   lv = N_STROBE'(3) << (N_STROBE - 2);
            default: lv = '1;
        endcase
        return lv;
    endfunction

endpackage

// File: rtl/keyscan_matrix.sv
module keyscan_matrix
    import keyscan_pkg::*;
#(
    parameter int SLOT_CLKS = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                sleep,
    input  logic [1:0]          lvl_sel,
    input  logic                restart,
    input  logic [N_RETURN-1:0] return_i,
    output logic [N_STROBE-1:0] strobe_o,
    output logic                scan_en,
    output logic [KEY_BITS-1:0] key_data
);
    localparam int ROW_W  = $clog2(N_STROBE);
    localparam int SLOT_W = (SLOT_CLKS > 1) ? $clog2(SLOT_CLKS) : 1;

    logic [ROW_W-1:0]    row_q;
    logic [SLOT_W-1:0]   slot_q;
    logic [KEY_BITS-1:0] acc_q;
    logic                active_q;
    logic [KEY_BITS-1:0] frame;

    assign scan_en  = !sleep || active_q;
    assign strobe_o = scan_en ? (N_STROBE'(1) << row_q) : sleep_levels(lvl_sel);

    always_comb begin
        frame = acc_q | (KEY_BITS'(return_i) << (int'(row_q) * N_RETURN));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            row_q    <= '0;
            slot_q   <= '0;
            acc_q    <= '0;
            key_data <= '0;
            active_q <= 1'b0;
        end else if (restart) begin
            row_q    <= '0;
            slot_q   <= '0;
            acc_q    <= '0;
            active_q <= 1'b1;
        end else if (!scan_en) begin
            row_q  <= '0;
            slot_q <= '0;
            acc_q  <= '0;
            if (|return_i) active_q <= 1'b1;
        end else begin
            if (!sleep) active_q <= 1'b1;
            if (slot_q == SLOT_W'(SLOT_CLKS - 1)) begin
                slot_q <= '0;
                if (row_q == ROW_W'(N_STROBE - 1)) begin
                    key_data <= frame;
                    acc_q    <= '0;
                    row_q    <= '0;
                    if (sleep && frame == '0) active_q <= 1'b0;
                end else begin
                    acc_q <= frame;
                    row_q <= row_q + 1'b1;
                end
            end else begin
                slot_q <= slot_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/keyscan_hold.sv
module keyscan_hold #(
    parameter int HOLD_CLKS = 38400,
    localparam int CNT_W = $clog2(HOLD_CLKS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             key_any,
    input  logic             read_done,
    output logic             req,
    output logic [CNT_W-1:0] hold_cnt
);
    always_ff @(posedge clk) begin
        if (rst) begin
            hold_cnt <= '0;
            req      <= 1'b0;
        end else begin
            if (!key_any) begin
                hold_cnt <= '0;
            end else if (hold_cnt < CNT_W'(HOLD_CLKS)) begin
                hold_cnt <= hold_cnt + 1'b1;
                if (hold_cnt == CNT_W'(HOLD_CLKS - 1)) req <= 1'b1;
            end
            if (read_done) req <= 1'b0;
        end
    end

endmodule

// File: rtl/keyscan_serial.sv
module keyscan_serial
    import keyscan_pkg::*;
#(
    parameter logic [CMD_BITS-1:0] READ_ADDR = 8'h8F,
    parameter logic [CMD_BITS-1:0] CTRL_ADDR = 8'h8C
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                ser_ce,
    input  logic                ser_clk,
    input  logic                ser_din,
    input  logic [KEY_BITS-1:0] key_data,
    input  logic                req,
    output logic                sdo_drive_low,
    output logic                read_done,
    output logic                ctrl_wr,
    output logic [CMD_BITS-1:0] ctrl_data
);
    localparam int BIT_W = $clog2(KEY_BITS + 1);

    logic                ce_q, sclk_q;
    logic [CMD_BITS-1:0] addr_sr;
    xfer_e               mode_q;
    logic [KEY_BITS-1:0] shift_q;
    logic [BIT_W-1:0]    bits_q;
    logic                sclk_rise, sclk_fall, ce_rise, ce_fall;

    assign sclk_rise = ser_clk && !sclk_q;
    assign sclk_fall = !ser_clk && sclk_q;
    assign ce_rise   = ser_ce && !ce_q;
    assign ce_fall   = !ser_ce && ce_q;

    assign sdo_drive_low = ser_ce ? (mode_q == XFER_READ && !shift_q[0]) : req;

    always_ff @(posedge clk) begin
        if (rst) begin
            ce_q      <= 1'b0;
            sclk_q    <= 1'b0;
            addr_sr   <= '0;
            ctrl_data <= '0;
            mode_q    <= XFER_IDLE;
            shift_q   <= '0;
            bits_q    <= '0;
            read_done <= 1'b0;
            ctrl_wr   <= 1'b0;
        end else begin
            ce_q      <= ser_ce;
            sclk_q    <= ser_clk;
            read_done <= 1'b0;
            ctrl_wr   <= 1'b0;
            if (ce_rise) begin
                mode_q  <= (addr_sr == READ_ADDR) ? XFER_READ :
                           (addr_sr == CTRL_ADDR) ? XFER_CTRL : XFER_IDLE;
                shift_q <= key_data;
                bits_q  <= '0;
            end else if (ce_fall) begin
                if (mode_q == XFER_READ && bits_q >= BIT_W'(KEY_BITS)) read_done <= 1'b1;
                if (mode_q == XFER_CTRL && bits_q >= BIT_W'(CMD_BITS)) ctrl_wr <= 1'b1;
                mode_q  <= XFER_IDLE;
                addr_sr <= '0;
            end else if (ser_ce) begin
                if (sclk_rise) begin
                    if (bits_q != '1) bits_q <= bits_q + 1'b1;
                    ctrl_data <= {ser_din, ctrl_data[CMD_BITS-1:1]};
                end
                if (sclk_fall && mode_q == XFER_READ) shift_q <= shift_q >> 1;
            end else if (sclk_rise) begin
                addr_sr <= {ser_din, addr_sr[CMD_BITS-1:1]};
            end
        end
    end

endmodule

// File: rtl/keyscan_ctrl.sv
module keyscan_ctrl
    import keyscan_pkg::*;
#(
    parameter int                  SLOT_CLKS = 4,
    parameter int                  HOLD_CLKS = 38400,
    parameter logic [CMD_BITS-1:0] READ_ADDR = 8'h8F,
    parameter logic [CMD_BITS-1:0] CTRL_ADDR = 8'h8C
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                ser_ce,
    input  logic                ser_clk,
    input  logic                ser_din,
    output logic                sdo_drive_low,
    output logic [N_STROBE-1:0] strobe_o,
    input  logic [N_RETURN-1:0] return_i,
    output logic                scan_en
);
    localparam int CNT_W = $clog2(HOLD_CLKS + 1);

    ctrl_t               ctrl_q;
    logic [KEY_BITS-1:0] key_data;
    logic                key_any;
    logic                req, read_done, ctrl_wr;
    logic [CMD_BITS-1:0] ctrl_data;
    logic [CNT_W-1:0]    hold_cnt;

    assign key_any = |key_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (ctrl_wr) begin
            ctrl_q.sleep   <= ctrl_data[0];
            ctrl_q.lvl_sel <= ctrl_data[2:1];
        end
    end

    keyscan_matrix #(.SLOT_CLKS(SLOT_CLKS)) i_matrix (
        .clk      (clk),
        .rst      (rst),
        .sleep    (ctrl_q.sleep),
        .lvl_sel  (ctrl_q.lvl_sel),
        .restart  (read_done),
        .return_i (return_i),
        .strobe_o (strobe_o),
        .scan_en  (scan_en),
        .key_data (key_data)
    );

    keyscan_hold #(.HOLD_CLKS(HOLD_CLKS)) i_hold (
        .clk       (clk),
        .rst       (rst),
        .key_any   (key_any),
        .read_done (read_done),
        .req       (req),
        .hold_cnt  (hold_cnt)
    );

    keyscan_serial #(.READ_ADDR(READ_ADDR), .CTRL_ADDR(CTRL_ADDR)) i_serial (
        .clk           (clk),
        .rst           (rst),
        .ser_ce        (ser_ce),
        .ser_clk       (ser_clk),
        .ser_din       (ser_din),
        .key_data      (key_data),
        .req           (req),
        .sdo_drive_low (sdo_drive_low),
        .read_done     (read_done),
        .ctrl_wr       (ctrl_wr),
        .ctrl_data     (ctrl_data)
    );

endmodule

// File: rtl/keyscan_checker.sv
module keyscan_checker
    import keyscan_pkg::*;
#(
    parameter int HOLD_CLKS = 38400,
    localparam int CNT_W = $clog2(HOLD_CLKS + 1)
) (
    input logic                clk,
    input logic                rst,
    input logic                scan_en,
    input logic [N_STROBE-1:0] strobe_o,
    input logic                read_done,
    input logic                ctrl_wr,
    input logic                sleep,
    input logic                req,
    input logic                key_any,
    input logic [CNT_W-1:0]    hold_cnt
);
    assert_one_strobe_R1: assert property (@(posedge clk) disable iff (rst)
        scan_en |-> $countones(strobe_o) == 1);

    assert_strobe_order_R1: assert property (@(posedge clk) disable iff (rst)
        (scan_en && $past(scan_en) && !$past(read_done) && strobe_o != $past(strobe_o))
        |-> strobe_o == {$past(strobe_o[N_STROBE-2:0]), $past(strobe_o[N_STROBE-1])});

    assert_rest_levels_R3: assert property (@(posedge clk) disable iff (rst)
        (!scan_en && $past(!scan_en) && !$past(ctrl_wr)) |-> $stable(strobe_o));

    assert_stop_only_asleep_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(scan_en) |-> sleep);

    assert_req_after_hold_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(req) |-> hold_cnt == CNT_W'(HOLD_CLKS));

    assert_read_clears_R9: assert property (@(posedge clk) disable iff (rst)
        read_done |=> !req);

    assert_release_resets_R11: assert property (@(posedge clk) disable iff (rst)
        !key_any |=> hold_cnt == '0);

endmodule

bind keyscan_ctrl keyscan_checker #(.HOLD_CLKS(HOLD_CLKS)) u_keyscan_checker (
    .clk       (clk),
    .rst       (rst),
    .scan_en   (scan_en),
    .strobe_o  (strobe_o),
    .read_done (read_done),
    .ctrl_wr   (ctrl_wr),
    .sleep     (ctrl_q.sleep),
    .req       (req),
    .key_any   (key_any),
    .hold_cnt  (hold_cnt)
);

// File: tb/test_keyscan_ctrl.sv
module test_keyscan_ctrl;
    localparam int SLOT = 4;
    localparam int HOLD = 400;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ser_ce = 1'b0, ser_clk = 1'b0, ser_din = 1'b0;
    logic       sdo_drive_low;
    logic [4:0] strobe_o, return_i;
    logic       scan_en;
    logic [24:0] keys = '0;
    int errors = 0, checks = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    keyscan_ctrl #(.SLOT_CLKS(SLOT), .HOLD_CLKS(HOLD)) i_keyscan_ctrl (
        .clk(clk), .rst(rst), .ser_ce(ser_ce), .ser_clk(ser_clk), .ser_din(ser_din),
        .sdo_drive_low(sdo_drive_low), .strobe_o(strobe_o), .return_i(return_i),
        .scan_en(scan_en)
    );

    // Matrix model: a pressed key joins its strobe to its return line.
    always_comb begin
        return_i = '0;
        for (int s = 0; s < 5; s++)
            for (int r = 0; r < 5; r++)
                if (keys[s*5+r] && strobe_o[s]) return_i[r] = 1'b1;
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ser_bit(input logic b);
        ser_din = b; ser_clk = 1'b1; wait_clk(2);
        ser_clk = 1'b0; wait_clk(2);
    endtask

    task automatic send_addr(input logic [7:0] a);
        ser_ce = 1'b0;
        for (int i = 0; i < 8; i++) ser_bit(a[i]);
        ser_ce = 1'b1; wait_clk(2);
    endtask

    task automatic write_ctrl(input logic [7:0] a, input logic [7:0] d);
        send_addr(a);
        for (int i = 0; i < 8; i++) ser_bit(d[i]);
        ser_ce = 1'b0; wait_clk(3);
    endtask

    task automatic read_keys(output logic [24:0] d);
        send_addr(8'h8F);
        for (int i = 0; i < 25; i++) begin
            d[i] = !sdo_drive_low;
            ser_bit(1'b0);
        end
        ser_ce = 1'b0; wait_clk(3);
    endtask

    task automatic t_reset;
        check(scan_en == 1'b1, "R12 scan_en after reset", 32'(scan_en), 1);
        check(sdo_drive_low == 1'b0, "R12 no request after reset", 32'(sdo_drive_low), 0);
    endtask

    task automatic t_scan_order;
        logic [4:0] prev;
        prev = strobe_o;
        while (!(strobe_o == 5'b00001 && prev != 5'b00001)) begin
            prev = strobe_o; wait_clk(1);
        end
        for (int s = 0; s < 5; s++) begin
            bit ok = 1'b1;
            logic [4:0] seen = '0;
            for (int c = 0; c < SLOT; c++) begin
                if (strobe_o != 5'(1 << s)) begin ok = 1'b0; seen = strobe_o; end
                wait_clk(1);
            end
            check(ok, "R1 strobe order and slot length", 32'(seen), 32'(1 << s));
        end
    endtask

    task automatic t_multi;
        logic [24:0] d;
        keys = 25'h1 | 25'h1 << 7 | 25'h1 << 24;
        wait_clk(50);
        read_keys(d);
        check(d == keys, "R2 R8 simultaneous keys read out", 32'(d), 32'(keys));
        keys = 25'h1 << 13;
        wait_clk(50);
        read_keys(d);
        check(d == keys, "R2 single key s2 r3", 32'(d), 32'(keys));
        keys = '0; wait_clk(60);
    endtask

    task automatic t_hold;
        logic [24:0] d;
        bit ok;
        keys = 25'h1 << 12;
        wait_clk(HOLD - 1);
        check(sdo_drive_low == 1'b0, "R6 no request before hold", 32'(sdo_drive_low), 0);
        wait_clk(46);
        check(sdo_drive_low == 1'b1, "R6 request after hold", 32'(sdo_drive_low), 1);
        ser_ce = 1'b1; wait_clk(2);
        check(sdo_drive_low == 1'b0, "R7 ce high releases request", 32'(sdo_drive_low), 0);
        ser_ce = 1'b0; wait_clk(2);
        check(sdo_drive_low == 1'b1, "R7 request back after ce low", 32'(sdo_drive_low), 1);
        read_keys(d);
        check(d == keys, "R8 key data during request", 32'(d), 32'(keys));
        check(sdo_drive_low == 1'b0, "R9 request cleared by read", 32'(sdo_drive_low), 0);
        ok = 1'b1;
        for (int i = 0; i < 500; i++) begin
            if (sdo_drive_low) ok = 1'b0;
            wait_clk(1);
        end
        check(ok, "R9 no second request in same hold", 32'(!ok), 0);
        keys = '0; wait_clk(60);
        keys = 25'h1 << 3; wait_clk(200);
        keys = '0; wait_clk(60);
        keys = 25'h1 << 3; wait_clk(300);
        check(sdo_drive_low == 1'b0, "R11 counter reset by release", 32'(sdo_drive_low), 0);
        wait_clk(HOLD + 45 - 300);
        check(sdo_drive_low == 1'b1, "R11 fresh full hold requests", 32'(sdo_drive_low), 1);
        read_keys(d);
        keys = '0; wait_clk(60);
    endtask

    task automatic t_levels;
        for (int sel = 0; sel < 4; sel++) begin
            logic [4:0] exp;
            exp = (sel == 0) ? 5'b00000 : (sel == 1) ? 5'b10000 : (sel == 2) ? 5'b11000 : 5'b11111;
            write_ctrl(8'h8C, 8'(1 | (sel << 1)));
            wait_clk(50);
            check(strobe_o == exp, "R3 R10 sleep strobe levels", 32'(strobe_o), 32'(exp));
            check(scan_en == 1'b0, "R5 rest after empty pass", 32'(scan_en), 0);
        end
    endtask

    task automatic t_wake;
        logic [24:0] d;
        write_ctrl(8'h8C, 8'h03);
        wait_clk(50);
        keys = 25'h1;
        wait_clk(30);
        check(scan_en == 1'b0, "R4 key on low strobe no wake", 32'(scan_en), 0);
        keys = '0; wait_clk(2);
        keys = 25'h1 << 21;
        wait_clk(3);
        check(scan_en == 1'b1, "R4 key on high strobe wakes", 32'(scan_en), 1);
        wait_clk(HOLD + 45);
        check(sdo_drive_low == 1'b1, "R6 request in sleep", 32'(sdo_drive_low), 1);
        read_keys(d);
        check(d == keys, "R2 key s4 r1 read in sleep", 32'(d), 32'(keys));
        check(sdo_drive_low == 1'b0, "R9 request cleared in sleep", 32'(sdo_drive_low), 0);
        keys = '0; wait_clk(60);
        check(scan_en == 1'b0, "R9 sleep kept after read", 32'(scan_en), 0);
        check(strobe_o == 5'b10000, "R5 rest levels after release", 32'(strobe_o), 32'(5'b10000));
    endtask

    task automatic t_ctrl_addr;
        write_ctrl(8'h55, 8'h00);
        wait_clk(10);
        check(scan_en == 1'b0, "R10 other address ignored", 32'(scan_en), 0);
        check(strobe_o == 5'b10000, "R10 levels unchanged", 32'(strobe_o), 32'(5'b10000));
        write_ctrl(8'h8C, 8'h00);
        check(scan_en == 1'b1, "R10 sleep left by write", 32'(scan_en), 1);
        wait_clk(30);
        check(scan_en == 1'b1, "R5 stays scanning awake", 32'(scan_en), 1);
    endtask

    initial begin
        wait_clk(3);
        rst = 1'b0;
        wait_clk(2);
        t_reset();
        t_scan_order();
        t_multi();
        t_hold();
        t_levels();
        t_wake();
        t_ctrl_addr();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule